// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block takes configuration words over a three-wire serial link (shift clock, data, load strobe) and files each completed 24-bit word into one of four configuration latches. The two least significant bits of the word select the target latch, so a host writes any latch with a single frame and a single strobe. All serial inputs are oversampled in the system clock domain, so no logic runs on the serial clock itself.

A chip-enable input gates the whole block. While it is low, every latch returns to its default value, the shift register is emptied and serial activity is ignored. After chip-enable rises, a ready flag goes high once a programmable settling delay has elapsed, and only then does the serial interface accept bits. A four-bit selector, held in a field of the function latch, drives a small debug multiplexer. That multiplexer can show constant levels, the ready flag, lock detect, two divider signals (raw or halved) or the data-rate clock, and it can release its output to high impedance.

Top module: `cfg_serial_loader`

## Requirements
- R1: Out of reset with chip_en low, reg_ref, reg_div and reg_mod are all zero, reg_fun is 24'h00000C (selector field bits [5:2] = 4'b0011), rdy is 0 and dbg_oe is 1.
- R2: After chip_en rises, rdy stays 0 for RDY_DLY system clocks and then goes to 1. Frames and strobes sent while rdy is 0 change no latch.
- R3: Each rising edge of ser_clk shifts ser_data into a 24-bit shift register, most significant bit first.
- R4: A rising edge of ser_load copies the shift register into the latch addressed by its bits [1:0]: 00 to reg_ref, 01 to reg_div, 10 to reg_mod, 11 to reg_fun. The other three latches keep their values.
- R5: When more than 24 ser_clk edges arrive before a strobe, only the last 24 bits are latched.
- R6: While chip_en is low, all latches hold their R1 defaults, rdy is 0 and serial frames are ignored. A frame sent during that time is absent from every latch after chip_en returns and rdy rises.
- R7: mux_sel always equals reg_fun[5:2]. Code 4'b0011 shows rdy on dbg_out.
- R8: Selector codes 4'b0000, 4'b0001, 4'b0100 and 4'b1010 drive dbg_out to 0, to 1, to lock_det and to rate_clk respectively.
- R9: Codes 4'b1000 and 4'b1001 pass ref_div and fb_div straight through. Codes 4'b0110 and 4'b0111 show a toggle that flips on each rising edge of ref_div and of fb_div. Both toggles clear to 0 on reset and while chip_en is low.
- R10: Code 4'b0010 drives dbg_oe to 0, and every other code drives dbg_oe to 1. Codes 4'b0101 and 4'b1011 through 4'b1111 drive dbg_out to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Block enable; low clears all state |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe; a rising edge files the word |
| lock_det | input | 1 | Lock-detect level for the debug mux |
| ref_div | input | 1 | Reference divider signal for the debug mux |
| fb_div | input | 1 | Feedback divider signal for the debug mux |
| rate_clk | input | 1 | Data-rate clock for the debug mux |
| reg_ref | output | WORD_W | Latch at address 00 |
| reg_div | output | WORD_W | Latch at address 01 |
| reg_mod | output | WORD_W | Latch at address 10 |
| reg_fun | output | WORD_W | Latch at address 11 |
| mux_sel | output | 4 | Debug selector taken from reg_fun[5:2] |
| dbg_out | output | 1 | Debug multiplexer output |
| dbg_oe | output | 1 | Debug output enable; low means high impedance |
| rdy | output | 1 | Ready flag after the settling delay |

## Verification
The hardest case to reach from the ports is a complete frame that arrives while chip_en is high but rdy is still low. The bench widens the settling delay so that a whole frame and strobe fit inside that window, then checks later that the target latch never changed. A second hard case is the pair of halved divider outputs, whose state depends on every edge seen since the last clear. The bench counts each rising edge it drives on ref_div and fb_div, then sweeps all sixteen selector codes against random source levels.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam int CFG_WORD_W   = 24;
  localparam int CFG_LATCHES  = 4;
  localparam int CFG_SEL_W    = 4;
  localparam int CFG_SEL_LSB  = 2;
  localparam int CFG_FUN_IDX  = 3;

  typedef enum logic [CFG_SEL_W-1:0] {
    DSEL_LOW   = 4'b0000,
    DSEL_HIGH  = 4'b0001,
    DSEL_HIZ   = 4'b0010,
    DSEL_RDY   = 4'b0011,
    DSEL_LOCK  = 4'b0100,
    DSEL_RHALF = 4'b0110,
    DSEL_NHALF = 4'b0111,
    DSEL_RDIV  = 4'b1000,
    DSEL_NDIV  = 4'b1001,
    DSEL_RATE  = 4'b1010
  } dbg_sel_e;

  localparam logic [CFG_SEL_W-1:0] CFG_SEL_DEFAULT = DSEL_RDY;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    assign chain_d = {chain_q[STAGES-2:0], d_i[b]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign q_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/cfg_word_loader.sv
module cfg_word_loader
  import cfg_loader_pkg::*;
#(
  parameter int WORD_W    = CFG_WORD_W,
  parameter int NUM_LATCH = CFG_LATCHES,
  parameter int SEL_LSB   = CFG_SEL_LSB,
  parameter int FUN_IDX   = CFG_FUN_IDX
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 ce_i,
  input  logic                                 en_i,
  input  logic                                 sclk_i,
  input  logic                                 sdata_i,
  input  logic                                 load_i,
  output logic [NUM_LATCH-1:0][WORD_W-1:0]     lat_o
);

  localparam int ADDR_W = $clog2(NUM_LATCH);

  logic                              sclk_prev_q;
  logic                              load_prev_q;
  logic                              sclk_rise;
  logic                              load_rise;
  logic [WORD_W-1:0]                 sreg_q;
  logic [WORD_W-1:0]                 sreg_d;
  logic [NUM_LATCH-1:0]              wr_en;
  logic [NUM_LATCH-1:0][WORD_W-1:0]  lat_q;
  logic [NUM_LATCH-1:0][WORD_W-1:0]  lat_d;
  logic [NUM_LATCH-1:0][WORD_W-1:0]  lat_def;

  assign sclk_rise = sclk_i & ~sclk_prev_q;
  assign load_rise = load_i & ~load_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      load_prev_q <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_i;
      load_prev_q <= load_i;
    end
  end

  // shift register, MSB first
  always_comb begin
    sreg_d = sreg_q;
    if (!ce_i) begin
      sreg_d = '0;
    end else if (en_i && sclk_rise) begin
      sreg_d = {sreg_q[WORD_W-2:0], sdata_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= sreg_d;
  end

  // latch bank, one write enable per address
  for (genvar i = 0; i < NUM_LATCH; i++) begin : g_latch
    if (i == FUN_IDX) begin : g_fun_def
      assign lat_def[i] = WORD_W'(CFG_SEL_DEFAULT) << SEL_LSB;
    end else begin : g_zero_def
      assign lat_def[i] = '0;
    end
    assign wr_en[i] = en_i & load_rise & (sreg_q[ADDR_W-1:0] == ADDR_W'(i));
    assign lat_d[i] = !ce_i    ? lat_def[i] :
                      wr_en[i] ? sreg_q     : lat_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= lat_def;
    else        lat_q <= lat_d;
  end

  assign lat_o = lat_q;

  a_r3_msb_first_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_i && en_i && sclk_rise) |=>
      (sreg_q[0] == $past(sdata_i)) && (sreg_q[WORD_W-1:1] == $past(sreg_q[WORD_W-2:0])));

  a_r4_addressed_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_i && en_i && load_rise) |=>
      lat_q[$past(sreg_q[ADDR_W-1:0])] == $past(sreg_q));

  a_r4_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_i && !(en_i && load_rise)) |=> $stable(lat_q));

  a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> (lat_q == lat_def) && (sreg_q == '0));

  a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

endmodule

// File: rtl/cfg_dbg_mux.sv
module cfg_dbg_mux
  import cfg_loader_pkg::*;
#(
  parameter int SEL_W  = CFG_SEL_W,
  parameter int N_HALF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             rdy_i,
  input  logic             lock_i,
  input  logic             ref_i,
  input  logic             fb_i,
  input  logic             rate_i,
  output logic             out_o,
  output logic             oe_o
);

  logic [N_HALF-1:0] src;
  logic [N_HALF-1:0] prev_q;
  logic [N_HALF-1:0] half_q;
  logic [N_HALF-1:0] half_d;
  logic [N_HALF-1:0] src_rise;

  assign src = {fb_i, ref_i};

  for (genvar g = 0; g < N_HALF; g++) begin : g_half
    assign src_rise[g] = src[g] & ~prev_q[g];
    assign half_d[g]   = !ce_i       ? 1'b0       :
                         src_rise[g] ? ~half_q[g] : half_q[g];

    a_r9_half_flips: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_i && src_rise[g]) |=> (half_q[g] != $past(half_q[g])));

    a_r9_half_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_i && !src_rise[g]) |=> $stable(half_q[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      half_q <= '0;
    end else begin
      prev_q <= src;
      half_q <= half_d;
    end
  end

  always_comb begin
    out_o = 1'b0;
    oe_o  = 1'b1;
    case (sel_i)
      DSEL_LOW:   out_o = 1'b0;
      DSEL_HIGH:  out_o = 1'b1;
      DSEL_HIZ:   oe_o  = 1'b0;
      DSEL_RDY:   out_o = rdy_i;
      DSEL_LOCK:  out_o = lock_i;
      DSEL_RHALF: out_o = half_q[0];
      DSEL_NHALF: out_o = half_q[1];
      DSEL_RDIV:  out_o = ref_i;
      DSEL_NDIV:  out_o = fb_i;
      DSEL_RATE:  out_o = rate_i;
      default:    out_o = 1'b0;
    endcase
  end

  a_r10_hiz_only_code: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> (sel_i == DSEL_HIZ));

  a_r9_half_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> (half_q == '0));

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int WORD_W  = CFG_WORD_W,
  parameter int RDY_DLY = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_load,
  input  logic              lock_det,
  input  logic              ref_div,
  input  logic              fb_div,
  input  logic              rate_clk,
  output logic [WORD_W-1:0] reg_ref,
  output logic [WORD_W-1:0] reg_div,
  output logic [WORD_W-1:0] reg_mod,
  output logic [WORD_W-1:0] reg_fun,
  output logic [3:0]        mux_sel,
  output logic              dbg_out,
  output logic              dbg_oe,
  output logic              rdy
);

  localparam int NUM_LATCH = CFG_LATCHES;
  localparam int CNT_W     = $clog2(RDY_DLY + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(RDY_DLY);

  logic [3:0]                        pins_s;
  logic                              ce_s;
  logic                              load_s;
  logic                              sclk_s;
  logic                              sdata_s;
  logic [CNT_W-1:0]                  cnt_q;
  logic [CNT_W-1:0]                  cnt_d;
  logic                              rdy_q;
  logic                              rdy_d;
  logic [NUM_LATCH-1:0][WORD_W-1:0]  lat;

  cfg_sync #(.W(4), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({chip_en, ser_load, ser_clk, ser_data}),
    .q_o   (pins_s)
  );

  assign {ce_s, load_s, sclk_s, sdata_s} = pins_s;

  // settling delay after enable
  always_comb begin
    cnt_d = cnt_q;
    if (!ce_s)                cnt_d = '0;
    else if (cnt_q != CNT_LIM) cnt_d = cnt_q + 1'b1;
  end

  assign rdy_d = ce_s & (cnt_q == CNT_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign rdy = rdy_q;

  cfg_word_loader #(
    .WORD_W    (WORD_W),
    .NUM_LATCH (NUM_LATCH),
    .SEL_LSB   (CFG_SEL_LSB),
    .FUN_IDX   (CFG_FUN_IDX)
  ) u_loader (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_i    (ce_s),
    .en_i    (rdy_q),
    .sclk_i  (sclk_s),
    .sdata_i (sdata_s),
    .load_i  (load_s),
    .lat_o   (lat)
  );

  assign reg_ref = lat[0];
  assign reg_div = lat[1];
  assign reg_mod = lat[2];
  assign reg_fun = lat[3];
  assign mux_sel = reg_fun[CFG_SEL_LSB +: CFG_SEL_W];

  cfg_dbg_mux #(.SEL_W(CFG_SEL_W), .N_HALF(2)) u_dbg (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_i   (ce_s),
    .sel_i  (mux_sel),
    .rdy_i  (rdy_q),
    .lock_i (lock_det),
    .ref_i  (ref_div),
    .fb_i   (fb_div),
    .rate_i (rate_clk),
    .out_o  (dbg_out),
    .oe_o   (dbg_oe)
  );

  a_r2_rdy_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !rdy);

  a_r2_rdy_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && ce_s) |=> rdy);

  a_r6_no_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_s && !rdy) |=> $stable({reg_ref, reg_div, reg_mod, reg_fun}));

endmodule

// File: tb/test_cfg_serial_loader.sv
module test_cfg_serial_loader;

  localparam int CLK_PERIOD = 10;
  localparam int WW         = 24;
  localparam int RDLY       = 300;
  localparam logic [WW-1:0] FUN_DEF = 24'h00000C;

  logic clk = 1'b0;
  logic rst_n, chip_en, ser_clk, ser_data, ser_load;
  logic lock_det, ref_div, fb_div, rate_clk;
  logic [WW-1:0] reg_ref, reg_div, reg_mod, reg_fun;
  logic [3:0] mux_sel;
  logic dbg_out, dbg_oe, rdy;

  int n_chk = 0;
  int n_fail = 0;
  logic [WW-1:0] model [4];
  int ref_edges = 0;
  int fb_edges = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_loader #(.WORD_W(WW), .RDY_DLY(RDLY)) i_cfg_serial_loader (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .ser_clk(ser_clk),
    .ser_data(ser_data), .ser_load(ser_load), .lock_det(lock_det),
    .ref_div(ref_div), .fb_div(fb_div), .rate_clk(rate_clk),
    .reg_ref(reg_ref), .reg_div(reg_div), .reg_mod(reg_mod), .reg_fun(reg_fun),
    .mux_sel(mux_sel), .dbg_out(dbg_out), .dbg_oe(dbg_oe), .rdy(rdy)
  );

  task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_defaults();
    model[0] = '0; model[1] = '0; model[2] = '0; model[3] = FUN_DEF;
    ref_edges = 0; fb_edges = 0;
  endtask

  task automatic send_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      tick(2);
      ser_clk = 1'b1;
      tick(3);
      ser_clk = 1'b0;
      tick(3);
    end
    ser_load = 1'b1;
    tick(4);
    ser_load = 1'b0;
    tick(4);
  endtask

  task automatic write_word(input logic [WW-1:0] w);
    send_bits({40'd0, w}, WW);
    model[w[1:0]] = w;
  endtask

  task automatic check_all(input string req);
    chk(req, reg_ref, model[0]);
    chk(req, reg_div, model[1]);
    chk(req, reg_mod, model[2]);
    chk(req, reg_fun, model[3]);
  endtask

  task automatic set_srcs(input logic l, input logic r, input logic f, input logic t);
    if (r && !ref_div) ref_edges++;
    if (f && !fb_div)  fb_edges++;
    lock_det = l; ref_div = r; fb_div = f; rate_clk = t;
    tick(3);
  endtask

  function automatic logic exp_out(input logic [3:0] s);
    case (s)
      4'b0000: return 1'b0;
      4'b0001: return 1'b1;
      4'b0011: return rdy;
      4'b0100: return lock_det;
      4'b0110: return ref_edges[0];
      4'b0111: return fb_edges[0];
      4'b1000: return ref_div;
      4'b1001: return fb_div;
      4'b1010: return rate_clk;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'b0011: return "R7 ready code";
      4'b0000, 4'b0001, 4'b0100, 4'b1010: return "R8 fixed/lock/rate";
      4'b0110, 4'b0111, 4'b1000, 4'b1001: return "R9 divider";
      default: return "R10 hiz/unused";
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [WW-1:0] w;
    void'($urandom(32'd2718));
    rst_n = 1'b0; chip_en = 1'b0; ser_clk = 1'b0; ser_data = 1'b0; ser_load = 1'b0;
    lock_det = 1'b0; ref_div = 1'b0; fb_div = 1'b0; rate_clk = 1'b0;
    model_defaults();
    tick(4);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    check_all("R1 reset defaults");
    chk("R1 rdy low", {23'd0, rdy}, 24'd0);
    chk("R1 oe high", {23'd0, dbg_oe}, 24'd1);
    chk("R7 default selector", {20'd0, mux_sel}, 24'd3);

    // R2 settling delay, frame ignored before ready
    chip_en = 1'b1;
    tick(5);
    chk("R2 rdy low early", {23'd0, rdy}, 24'd0);
    send_bits({40'd0, 24'hA5A5A6}, WW);
    chk("R2 rdy still low after frame", {23'd0, rdy}, 24'd0);
    tick(RDLY);
    chk("R2 rdy high after delay", {23'd0, rdy}, 24'd1);
    check_all("R2 frame before ready ignored");

    // R4 directed writes to each address
    write_word(24'h123450); check_all("R4 write addr 00");
    write_word(24'hABCDE1); check_all("R4 write addr 01");
    write_word(24'h0F0F02); check_all("R4 write addr 10");
    write_word(24'h800003); check_all("R4 write addr 11");
    chk("R7 selector from function latch", {20'd0, mux_sel}, 24'd0);

    // R3 MSB-first: asymmetric patterns
    write_word(24'h800001); check_all("R3 msb first high bit");
    write_word(24'h000005); check_all("R3 msb first low bits");

    // R5 over-long frame keeps the last 24 bits
    send_bits({34'd0, 6'b101101, 24'h3C3C3E}, 30);
    model[2] = 24'h3C3C3E;
    check_all("R5 last 24 bits kept");

    // random writes (R4 R3 R7)
    for (int k = 0; k < 20; k++) begin
      w = WW'($urandom());
      write_word(w);
      check_all("R4 random write");
      chk("R7 random selector", {20'd0, mux_sel}, {20'd0, model[3][5:2]});
    end

    // R6 disable clears and blocks the interface
    chip_en = 1'b0;
    tick(6);
    model_defaults();
    check_all("R6 disable clears latches");
    chk("R6 rdy low while disabled", {23'd0, rdy}, 24'd0);
    send_bits({40'd0, 24'h777771}, WW);
    chip_en = 1'b1;
    tick(RDLY + 10);
    check_all("R6 frame while disabled ignored");
    chk("R7 ready shown on debug", {23'd0, dbg_out}, 24'd1);

    // debug mux sweep (R7 R8 R9 R10)
    for (int c = 0; c < 16; c++) begin
      w = {WW'($urandom()) & 24'hFFFFC0} | (WW'(c) << 2) | 24'd3;
      write_word(w);
      for (int p = 0; p < 6; p++) begin
        logic [3:0] r4;
        r4 = 4'($urandom());
        set_srcs(r4[0], r4[1], r4[2], r4[3]);
        chk(req_of(4'(c)), {23'd0, dbg_out}, {23'd0, exp_out(4'(c))});
        chk("R10 output enable", {23'd0, dbg_oe}, {23'd0, (c != 2)});
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule